// File: doc/BRIEF.md
# Chainable Key State Readout Port

This block hands eight qualified key states, produced by upstream channel logic, to a host controller over two paths. A parallel path presents all eight states at once on an active-low data bus, and drives it only while the host pulls an active-low select input low. Several devices can therefore share one bus and be polled in turn. The block generates only the pad output-enable for this bus. The pads themselves, and any pull resistors, sit outside it.

The serial path uses one host clock line for two jobs. When the host holds the line high for a long time, the block captures the key states into an eight-bit shift register. A short high pulse instead moves the register on by one bit. The line is sampled by the fast system clock through a synchronizer, and the block measures the length of each high phase with a counter against the `LOAD_CYCLES` parameter. Bits leave least significant first and are active low. The bit position emptied by each shift is refilled from a chain input, so the serial output of one device can feed the chain input of the next and the host reads many devices as one stream. An any-key-active flag, also active low, tells the host that there is something to read.

Top module: `key_readout_port`

## Requirements
- R1: While `bus_en_n_i` is 0, `bus_oe_o` is 1 and `bus_q_n_o[i]` equals the inverse of `key_act_i[i]` (0 means key i pressed), one system clock after the key input.
- R2: While `bus_en_n_i` is 1, `bus_oe_o` is 0 and `bus_q_n_o` is all ones.
- R3: `any_n_o` is 0 one system clock after any bit of `key_act_i` is 1, and 1 one clock after all bits are 0.
- R4: When the synchronized serial clock has been high for `LOAD_CYCLES` system clocks in a row, the register captures the inverted key states, and bit 0 of that capture then appears on `sout_o` without any further clock edge.
- R5: A serial clock high phase shorter than `LOAD_CYCLES` system clocks shifts the register by exactly one bit on its rising edge. After the load, successive shifts present bits 1 to 7 in ascending order.
- R6: Each shift fills bit 7 from `sin_i`. After eight shifts following a load, `sout_o` shows the chain input values in the order they were shifted in (1 is inactive, 0 is pressed).
- R7: From reset until the first load, `sout_o` is 1, and serial clock pulses have no effect even when `sin_i` is 0.
- R8: A new load in the middle of a stream discards the remaining bits and restarts the output at bit 0 of the newly captured states. A load takes priority over a shift that falls in the same cycle.
- R9: A high phase longer than `LOAD_CYCLES` loads only once. Key changes that occur after the capture, while the line is still high, do not alter the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| key_act_i | input | NKEYS | Qualified key states, 1 = pressed |
| bus_en_n_i | input | 1 | Parallel bus select, active low |
| bus_q_n_o | output | NKEYS | Parallel key data, active low |
| bus_oe_o | output | 1 | Output enable for the parallel bus pads |
| sclk_i | input | 1 | Host serial clock: long high loads, short high shifts |
| sin_i | input | 1 | Chain input, active low, 1 when idle |
| sout_o | output | 1 | Serial key data, active low, bit 0 first |
| any_n_o | output | 1 | Any-key-active flag, active low |

## Verification
The checker watches four things on every clock. It checks that a released bus carries all ones, that the parallel image and the any-key flag track the keys with one clock of delay, that bit 0 of each capture reaches the serial output right after the load decision, and that the serial output stays idle before the first load. Other behaviour needs the bench's scenarios, because it depends on the length of the serial clock's high phases. These are the ascending bit order, refill from the chain input, the near-threshold pulse that must still count as a shift, a restart in the middle of a stream, and a single capture during an over-long hold.

// File: rtl/key_readout_pkg.sv
package key_readout_pkg;
  // Action decided for the shift register in a given system clock cycle
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_SHIFT = 2'd1,
    OP_LOAD  = 2'd2
  } shift_op_e;
endpackage

// File: rtl/sclk_qualifier.sv
module sclk_qualifier
  import key_readout_pkg::*;
#(
  parameter int LOAD_CYCLES = 425000,
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_i,
  output shift_op_e op_o
);
  localparam int CW = $clog2(LOAD_CYCLES + 1);
  localparam logic [CW-1:0] CNT_SAT  = CW'(LOAD_CYCLES);
  localparam logic [CW-1:0] CNT_FIRE = CW'(LOAD_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   hi, rise;

  always_comb begin
    hi   = sync_q[SYNC_STAGES-1];
    rise = hi & ~prev_q;
    if (!hi)                 cnt_d = '0;
    else if (cnt_q == CNT_SAT) cnt_d = cnt_q;
    else                     cnt_d = cnt_q + 1'b1;
    if (hi && (cnt_q == CNT_FIRE)) op_o = OP_LOAD;
    else if (rise)                 op_o = OP_SHIFT;
    else                           op_o = OP_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_i};
      prev_q <= hi;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/chain_shifter.sv
module chain_shifter
  import key_readout_pkg::*;
#(
  parameter int NKEYS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  shift_op_e        op_i,
  input  logic [NKEYS-1:0] key_act_i,
  input  logic             sin_i,
  output logic             sout_o
);
  logic [NKEYS-1:0] sh_q, sh_d;
  logic             loaded_q, loaded_d;
  logic             sh_en;

  always_comb begin
    sh_d     = sh_q;
    loaded_d = loaded_q;
    sh_en    = 1'b0;
    unique case (op_i)
      OP_LOAD: begin
        sh_d     = ~key_act_i;
        loaded_d = 1'b1;
        sh_en    = 1'b1;
      end
      OP_SHIFT: begin
        sh_d  = {sin_i, sh_q[NKEYS-1:1]};
        sh_en = loaded_q;
      end
      default: sh_en = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q     <= '1;
      loaded_q <= 1'b0;
    end else if (sh_en) begin
      sh_q     <= sh_d;
      loaded_q <= loaded_d;
    end
  end

  assign sout_o = loaded_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/par_image.sv
module par_image #(
  parameter int NKEYS = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKEYS-1:0] key_act_i,
  input  logic             bus_en_n_i,
  output logic [NKEYS-1:0] bus_q_n_o,
  output logic             bus_oe_o,
  output logic             any_n_o
);
  logic [NKEYS-1:0] img_q, img_d;
  logic             any_q, any_d;

  always_comb begin
    img_d = ~key_act_i;
    any_d = ~(|key_act_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      img_q <= '1;
      any_q <= 1'b1;
    end else begin
      img_q <= img_d;
      any_q <= any_d;
    end
  end

  assign bus_oe_o  = ~bus_en_n_i;
  assign bus_q_n_o = bus_en_n_i ? '1 : img_q;
  assign any_n_o   = any_q;
endmodule

// File: rtl/key_readout_port.sv
module key_readout_port
  import key_readout_pkg::*;
#(
  parameter int NKEYS       = 8,
  parameter int LOAD_CYCLES = 425000,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NKEYS-1:0] key_act_i,
  input  logic             bus_en_n_i,
  output logic [NKEYS-1:0] bus_q_n_o,
  output logic             bus_oe_o,
  input  logic             sclk_i,
  input  logic             sin_i,
  output logic             sout_o,
  output logic             any_n_o
);
  shift_op_e op;

  sclk_qualifier #(.LOAD_CYCLES(LOAD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .op_o(op)
  );

  chain_shifter #(.NKEYS(NKEYS)) u_shift (
    .clk(clk), .rst_n(rst_n), .op_i(op), .key_act_i(key_act_i),
    .sin_i(sin_i), .sout_o(sout_o)
  );

  par_image #(.NKEYS(NKEYS)) u_par (
    .clk(clk), .rst_n(rst_n), .key_act_i(key_act_i), .bus_en_n_i(bus_en_n_i),
    .bus_q_n_o(bus_q_n_o), .bus_oe_o(bus_oe_o), .any_n_o(any_n_o)
  );
endmodule

// File: rtl/key_readout_chk.sv
module key_readout_chk
  import key_readout_pkg::*;
#(
  parameter int NKEYS = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NKEYS-1:0] key_act_i,
  input logic [NKEYS-1:0] bus_q_n_o,
  input logic             bus_oe_o,
  input logic             sout_o,
  input logic             any_n_o,
  input shift_op_e        op
);
  logic up_q, seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_q   <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      up_q <= 1'b1;
      if (op == OP_LOAD) seen_q <= 1'b1;
    end
  end

  // R1
  par_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && bus_oe_o) |-> (bus_q_n_o == ~$past(key_act_i)));

  // R2
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe_o |-> (bus_q_n_o == '1));

  // R3
  any_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    up_q |-> (any_n_o == ($past(key_act_i) == '0)));

  // R4
  load_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_LOAD) |=> (sout_o == !$past(key_act_i[0])));

  // R7
  idle_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> sout_o);
endmodule

bind key_readout_port key_readout_chk #(.NKEYS(NKEYS)) u_chk (
  .clk(clk), .rst_n(rst_n), .key_act_i(key_act_i), .bus_q_n_o(bus_q_n_o),
  .bus_oe_o(bus_oe_o), .sout_o(sout_o), .any_n_o(any_n_o), .op(op)
);

// File: tb/tb_key_readout_port.sv
module tb_key_readout_port;
  localparam int NK   = 8;
  localparam int LOAD = 40;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NK-1:0] keys;
  logic          en_n, sclk, sin;
  logic [NK-1:0] bus_q_n;
  logic          bus_oe, sout, any_n;

  int total = 0;
  int passed = 0;
  bit done = 1'b0;

  bit    exp_q[$];
  string tag_q[$];
  event  chk_ev;

  always #2 clk = ~clk;

  key_readout_port #(.NKEYS(NK), .LOAD_CYCLES(LOAD)) dut (
    .clk(clk), .rst_n(rst_n), .key_act_i(keys), .bus_en_n_i(en_n),
    .bus_q_n_o(bus_q_n), .bus_oe_o(bus_oe), .sclk_i(sclk), .sin_i(sin),
    .sout_o(sout), .any_n_o(any_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (ok) passed++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  // monitor: pops expected serial bits and compares them with sout
  always @(chk_ev) begin
    while (exp_q.size() > 0) begin
      automatic bit    e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(sout == e, t, 32'(sout), 32'(e));
    end
  end

  task automatic expect_bit(input bit e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    -> chk_ev;
    #1;
  endtask

  task automatic pulse(input int high);
    @(negedge clk) sclk = 1'b1;
    repeat (high) @(negedge clk);
    sclk = 1'b0;
    repeat (10) @(negedge clk);
  endtask

  task automatic stream(input logic [NK-1:0] k, input bit s);
    keys = k;
    sin  = s;
    pulse(LOAD + 20);
    expect_bit(~k[0], "R4 load bit0");
    for (int i = 1; i < NK; i++) begin
      pulse(6);
      expect_bit(~k[i], "R5 shifted bit");
    end
    for (int j = 0; j < 2; j++) begin
      pulse(6);
      expect_bit(s, "R6 chain bit");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", passed, total);
      $finish;
    end
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; keys = '0; en_n = 1'b1; sclk = 1'b0; sin = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sout == 1'b1, "R7 reset sout", 32'(sout), 32'd1);
    check(any_n == 1'b1, "R3 reset any", 32'(any_n), 32'd1);
    check(bus_oe == 1'b0 && bus_q_n == '1, "R2 reset bus", {23'd0, bus_oe, bus_q_n}, 32'h0ff);

    // R7: pulses before the first load do nothing
    sin = 1'b0;
    pulse(6);
    pulse(6);
    check(sout == 1'b1, "R7 shift before load", 32'(sout), 32'd1);

    // R1 / R2 / R3 parallel path
    keys = 8'hA5; en_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_oe == 1'b1 && bus_q_n == 8'h5A, "R1 parallel data", {23'd0, bus_oe, bus_q_n}, 32'h15a);
    check(any_n == 1'b0, "R3 any active", 32'(any_n), 32'd0);
    en_n = 1'b1;
    #1;
    check(bus_oe == 1'b0 && bus_q_n == 8'hFF, "R2 released", {23'd0, bus_oe, bus_q_n}, 32'h0ff);
    keys = 8'h00;
    repeat (3) @(negedge clk);
    check(any_n == 1'b1, "R3 none active", 32'(any_n), 32'd1);
    keys = 8'h80;
    repeat (3) @(negedge clk);
    check(any_n == 1'b0, "R3 top key only", 32'(any_n), 32'd0);

    // serial streams with the two chain input levels
    stream(8'h35, 1'b0);
    stream(8'hC8, 1'b1);

    // R8: reload in the middle of a stream
    sin = 1'b1;
    keys = 8'h96;
    pulse(LOAD + 20);
    expect_bit(1'b1, "R8 first load bit0");
    pulse(6); expect_bit(1'b0, "R8 first load bit1");
    pulse(6); expect_bit(1'b0, "R8 first load bit2");
    keys = 8'h01;
    pulse(LOAD + 20);
    expect_bit(1'b0, "R8 reload bit0");
    pulse(6); expect_bit(1'b1, "R8 reload bit1");
    // R5: a high phase just under the threshold still shifts
    pulse(LOAD - 10);
    expect_bit(1'b1, "R5 near-threshold shift bit2");

    // R9: long hold captures once; later key changes are not taken
    keys = 8'h00;
    @(negedge clk) sclk = 1'b1;
    repeat (LOAD + 10) @(negedge clk);
    keys = 8'hFF;
    repeat (20) @(negedge clk);
    sclk = 1'b0;
    repeat (10) @(negedge clk);
    expect_bit(1'b1, "R9 bit0 after long hold");
    pulse(6); expect_bit(1'b1, "R9 bit1 after long hold");

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule